// File: doc/BRIEF.md
# Page Entry Permission Checker

This block takes one leaf page-table entry that an earlier stage has already fetched, together with the access being attempted, and decides whether the access may proceed. The access is described by its kind (instruction fetch, data load or data store), the current privilege level, the virtual address, the page-size exponent and a flag that selects the wide (64-bit) or narrow (32-bit) entry format. The block returns a 3-bit result code, the translated physical address, the read/write/execute rights the entry grants and the privilege level held in the entry.

An entry can break more than one rule at once. The checks therefore run in a fixed priority order and only the highest-priority fault is reported. The physical frame number in the entry may carry software-owned bits below the page boundary of a large page. These bits are cleared before the frame is combined with the page offset taken from the virtual address.

All outputs are registered. One cycle after the input strobe, a single output strobe marks them as valid. There is no backpressure and no state other than the output register, so a new request may be presented on every cycle.

Top module: `pte_perm_chk`

## Requirements
- R1: `out_vld` is high in the cycle after a cycle with `in_vld` high, and low in the cycle after a cycle with `in_vld` low. Synchronous reset clears `out_vld`, `out_code`, `out_pa` and the permission outputs to zero.
- R2: When entry bit 0 (valid) is 0, the code is 1 (invalid). This holds whatever else is wrong with the entry or the access.
- R3: On a valid entry, an access code 0 (fetch) with entry bit 6 (no-execute) set gives code 2. A load with entry bit 5 (no-read) set gives code 3. The no-execute check comes first. No-read never affects fetches or stores, and no-execute never affects loads or stores.
- R4: Entry bits 3:2 hold the entry privilege level and bit 4 selects exact-level mode. When bit 4 is 0, a current level numerically greater than the entry level gives code 4. When bit 4 is 1, any current level other than the entry level gives code 4. This check comes after the checks of R3.
- R5: Access code 2 (store) to an entry whose bit 1 (dirty/writable) is 0 gives code 5. This is the lowest-priority fault. An access that passes every check gives code 0.
- R6: When `in_mode64` is 0, entry bits 4, 5 and 6 are treated as 0, and the frame number is taken from entry bits 31:12 only. When `in_mode64` is 1, the frame number is entry bits 47:12.
- R7: The page-size exponent is limited to the range 12 to 30: a value below 12 counts as 12 and a value above 30 counts as 30. For an exponent `ps`, `out_pa` is the frame number shifted left by 12 with bits below `ps` cleared, ORed with virtual address bits below `ps`.
- R8: On code 0, read is granted, write equals entry bit 1 and execute equals the inverse of the effective no-execute bit. On any fault, `out_pa` and all three permission outputs are 0. `out_plv` always shows entry bits 3:2.
- R9: Access code 3 is treated exactly like a load (code 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_entry | input | 64 | Leaf page-table entry |
| in_ps | input | 5 | Page-size exponent |
| in_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| in_cur_plv | input | 2 | Current privilege level |
| in_va | input | 64 | Virtual address |
| in_mode64 | input | 1 | 1 selects the wide entry format, 0 the narrow one |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_code | output | 3 | 0 match, 1 invalid, 2 no-execute, 3 no-read, 4 privilege, 5 dirty |
| out_pa | output | 48 | Physical address (0 on a fault) |
| out_perm_r | output | 1 | Read granted |
| out_perm_w | output | 1 | Write granted |
| out_perm_x | output | 1 | Execute granted |
| out_plv | output | 2 | Privilege level held in the entry |

## Verification
The fault checks can all trigger on the same request, and only one code may be reported. The bench therefore builds entries that break several rules at once: invalid with no-execute and a privilege violation, or a clean store with no-read and no-execute set. The reported code is judged against the priority order of R2 to R5. Large-page frame masking and the privilege decision also fall in the same cycle. To exercise them together, random requests with random exponents, levels and formats are compared on every clock against a behavioural reference model.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

    parameter int ENTRY_W    = 64;
    parameter int VA_W       = 64;
    parameter int PA_W       = 48;
    parameter int PLV_W      = 2;
    parameter int PS_W       = 5;
    parameter int PAGE_SHIFT = 12;
    parameter int PS_MIN     = 12;
    parameter int PS_MAX     = 30;
    parameter int NARROW_TOP = 31;

    localparam int FRAME_W  = PA_W - PAGE_SHIFT;
    localparam int NFRAME_W = NARROW_TOP + 1 - PAGE_SHIFT;

    // entry bit positions
    localparam int B_VALID = 0;
    localparam int B_DIRTY = 1;
    localparam int B_PLV   = 2;
    localparam int B_EXACT = B_PLV + PLV_W;
    localparam int B_NORD  = B_EXACT + 1;
    localparam int B_NOEX  = B_NORD + 1;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        RES_MATCH   = 3'd0,
        RES_INVALID = 3'd1,
        RES_NOEXEC  = 3'd2,
        RES_NOREAD  = 3'd3,
        RES_PRIV    = 3'd4,
        RES_DIRTY   = 3'd5
    } res_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             exact_plv;
        logic             no_read;
        logic             no_exec;
        logic [PLV_W-1:0] plv;
        logic [PA_W-1:0]  frame_base;
    } pte_f_t;

    function automatic logic [PS_W-1:0] clamp_ps(input logic [PS_W-1:0] ps);
        if (ps < PS_W'(PS_MIN))
            return PS_W'(PS_MIN);
        else if (ps > PS_W'(PS_MAX))
            return PS_W'(PS_MAX);
        return ps;
    endfunction

endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
    import pte_chk_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               mode64,
    output pte_f_t             fields
);
    logic [FRAME_W-1:0] frame;
    logic               unused_entry_bits;

    assign unused_entry_bits = ^{entry[PAGE_SHIFT-1:B_NOEX+1], entry[ENTRY_W-1:PA_W]};

    always_comb begin
        if (mode64)
            frame = entry[PA_W-1:PAGE_SHIFT];
        else
            frame = FRAME_W'(entry[NARROW_TOP:PAGE_SHIFT]);
        fields.valid      = entry[B_VALID];
        fields.dirty      = entry[B_DIRTY];
        fields.plv        = entry[B_PLV +: PLV_W];
        fields.exact_plv  = mode64 & entry[B_EXACT];
        fields.no_read    = mode64 & entry[B_NORD];
        fields.no_exec    = mode64 & entry[B_NOEX];
        fields.frame_base = {frame, {PAGE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/pte_fault_prio.sv
module pte_fault_prio
    import pte_chk_pkg::*;
(
    input  pte_f_t           fields,
    input  logic [1:0]       acc,
    input  logic [PLV_W-1:0] cur_plv,
    output res_e             code
);
    logic is_fetch, is_store, is_load, priv_bad;
    logic unused_frame;

    assign unused_frame = ^fields.frame_base;
    assign is_fetch = (acc_e'(acc) == ACC_FETCH);
    assign is_store = (acc_e'(acc) == ACC_STORE);
    assign is_load  = !is_fetch && !is_store;
    assign priv_bad = fields.exact_plv ? (cur_plv != fields.plv)
                                       : (cur_plv > fields.plv);

    always_comb begin
        if (!fields.valid)
            code = RES_INVALID;
        else if (is_fetch && fields.no_exec)
            code = RES_NOEXEC;
        else if (is_load && fields.no_read)
            code = RES_NOREAD;
        else if (priv_bad)
            code = RES_PRIV;
        else if (is_store && !fields.dirty)
            code = RES_DIRTY;
        else
            code = RES_MATCH;
    end
endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form
    import pte_chk_pkg::*;
(
    input  logic [PA_W-1:0] frame_base,
    input  logic [VA_W-1:0] va,
    input  logic [PS_W-1:0] ps,
    output logic [PA_W-1:0] pa
);
    logic [PS_W-1:0] ps_eff;
    logic [PA_W-1:0] off_mask;
    logic            unused_va_hi;

    generate
        if (VA_W > PA_W) begin : g_va_wide
            assign unused_va_hi = ^va[VA_W-1:PA_W];
        end else begin : g_va_narrow
            assign unused_va_hi = 1'b0;
        end
    endgenerate

    assign ps_eff   = clamp_ps(ps);
    assign off_mask = (PA_W'(1) << ps_eff) - PA_W'(1);
    assign pa       = (frame_base & ~off_mask) | (va[PA_W-1:0] & off_mask);
endmodule

// File: rtl/pte_perm_chk.sv
module pte_perm_chk
    import pte_chk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [ENTRY_W-1:0] in_entry,
    input  logic [PS_W-1:0]    in_ps,
    input  logic [1:0]         in_acc,
    input  logic [PLV_W-1:0]   in_cur_plv,
    input  logic [VA_W-1:0]    in_va,
    input  logic               in_mode64,
    output logic               out_vld,
    output logic [2:0]         out_code,
    output logic [PA_W-1:0]    out_pa,
    output logic               out_perm_r,
    output logic               out_perm_w,
    output logic               out_perm_x,
    output logic [PLV_W-1:0]   out_plv
);
    pte_f_t          fields;
    res_e            code;
    logic [PA_W-1:0] pa;
    logic            hit;

    pte_field_decode u_decode (
        .entry  (in_entry),
        .mode64 (in_mode64),
        .fields (fields)
    );

    pte_fault_prio u_prio (
        .fields  (fields),
        .acc     (in_acc),
        .cur_plv (in_cur_plv),
        .code    (code)
    );

    pte_addr_form u_addr (
        .frame_base (fields.frame_base),
        .va         (in_va),
        .ps         (in_ps),
        .pa         (pa)
    );

    assign hit = (code == RES_MATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            out_code   <= 3'd0;
            out_pa     <= '0;
            out_perm_r <= 1'b0;
            out_perm_w <= 1'b0;
            out_perm_x <= 1'b0;
            out_plv    <= '0;
        end else begin
            out_vld    <= in_vld;
            out_code   <= code;
            out_pa     <= hit ? pa : '0;
            out_perm_r <= hit;
            out_perm_w <= hit & fields.dirty;
            out_perm_x <= hit & ~fields.no_exec;
            out_plv    <= fields.plv;
        end
    end
endmodule

// File: rtl/pte_perm_chk_sva.sv
module pte_perm_chk_sva (
    input logic        clk,
    input logic        rst,
    input logic        in_vld,
    input logic        ent_valid,
    input logic        ent_dirty,
    input logic        ent_noex,
    input logic [1:0]  in_acc,
    input logic        in_mode64,
    input logic [11:0] va_low,
    input logic        out_vld,
    input logic [2:0]  out_code,
    input logic [11:0] pa_low,
    input logic        out_perm_r,
    input logic        out_perm_w,
    input logic        out_perm_x
);
    a_r1_vld_follow: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    a_r2_invalid_first: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !ent_valid) |=> (out_code == 3'd1));
    a_r5_dirty_store_ok: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ent_valid && ent_dirty && in_acc == 2'd2) |=> (out_code != 3'd5));
    a_r6_narrow_no_xi: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_mode64 && ent_noex && in_acc == 2'd0) |=> (out_code != 3'd2));
    a_r7_offset_pass: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ent_valid) |=> ((out_code != 3'd0) || (pa_low == $past(va_low))));
    a_r8_fault_no_perm: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_code != 3'd0) |-> (!out_perm_r && !out_perm_w && !out_perm_x));
    a_r8_match_read: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_code == 3'd0) |-> out_perm_r);
endmodule

bind pte_perm_chk pte_perm_chk_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .ent_valid  (in_entry[0]),
    .ent_dirty  (in_entry[1]),
    .ent_noex   (in_entry[6]),
    .in_acc     (in_acc),
    .in_mode64  (in_mode64),
    .va_low     (in_va[11:0]),
    .out_vld    (out_vld),
    .out_code   (out_code),
    .pa_low     (out_pa[11:0]),
    .out_perm_r (out_perm_r),
    .out_perm_w (out_perm_w),
    .out_perm_x (out_perm_x)
);

// File: tb/pte_perm_chk_tb.sv
module pte_perm_chk_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [63:0] in_entry = '0;
    logic [4:0]  in_ps = 5'd12;
    logic [1:0]  in_acc = '0;
    logic [1:0]  in_cur_plv = '0;
    logic [63:0] in_va = '0;
    logic        in_mode64 = 1'b1;
    logic        out_vld;
    logic [2:0]  out_code;
    logic [47:0] out_pa;
    logic        out_perm_r, out_perm_w, out_perm_x;
    logic [1:0]  out_plv;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pte_perm_chk u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_entry(in_entry), .in_ps(in_ps),
        .in_acc(in_acc), .in_cur_plv(in_cur_plv), .in_va(in_va), .in_mode64(in_mode64),
        .out_vld(out_vld), .out_code(out_code), .out_pa(out_pa),
        .out_perm_r(out_perm_r), .out_perm_w(out_perm_w), .out_perm_x(out_perm_x),
        .out_plv(out_plv)
    );

    function automatic logic [63:0] mk(input bit v, input bit d, input int plv, input bit ex,
                                       input bit nr, input bit nx, input logic [35:0] frame);
        logic [63:0] e = '0;
        e[0] = v; e[1] = d; e[3:2] = plv[1:0]; e[4] = ex; e[5] = nr; e[6] = nx;
        e[47:12] = frame;
        return e;
    endfunction

    // behavioural reference: returns {code, pa, r, w, x, plv}
    task automatic model(input logic [63:0] e, input int ps, input int acc, input int cur,
                         input logic [63:0] va, input bit m64,
                         output int code, output logic [47:0] pa, output logic [2:0] rwx,
                         output int plv);
        int p;
        bit ex, nr, nx;
        logic [47:0] fr, base, off;
        p = (ps < 12) ? 12 : ((ps > 30) ? 30 : ps);
        plv = int'(e[3:2]);
        ex = m64 ? e[4] : 1'b0;
        nr = m64 ? e[5] : 1'b0;
        nx = m64 ? e[6] : 1'b0;
        fr = m64 ? {e[47:12], 12'h000} : {16'h0, e[31:12], 12'h000};
        if (!e[0]) code = 1;
        else if (acc == 0 && nx) code = 2;
        else if ((acc == 1 || acc == 3) && nr) code = 3;
        else if ((!ex && cur > plv) || (ex && cur != plv)) code = 4;
        else if (acc == 2 && !e[1]) code = 5;
        else code = 0;
        base = (fr >> p) << p;
        off  = va[47:0] - ((va[47:0] >> p) << p);
        if (code == 0) begin
            pa = base + off;
            rwx = {1'b1, e[1], ~nx};
        end else begin
            pa = '0;
            rwx = 3'b000;
        end
    endtask

    task automatic cyc(input string tag, input bit vld, input logic [63:0] e, input int ps,
                       input int acc, input int cur, input logic [63:0] va, input bit m64,
                       input int want_code);
        int ec, ep;
        logic [47:0] epa;
        logic [2:0] erwx;
        in_vld = vld; in_entry = e; in_ps = 5'(ps); in_acc = 2'(acc);
        in_cur_plv = 2'(cur); in_va = va; in_mode64 = m64;
        model(e, ps, acc, cur, va, m64, ec, epa, erwx, ep);
        @(posedge clk);
        #1;
        checks++;
        if (!vld) begin
            if (out_vld !== 1'b0) begin
                errors++;
                $display("FAIL %s out_vld act=%b exp=0", tag, out_vld);
            end
        end else if (out_vld !== 1'b1 || int'(out_code) != ec || out_pa !== epa ||
                     {out_perm_r, out_perm_w, out_perm_x} !== erwx || int'(out_plv) != ep ||
                     (want_code >= 0 && ec != want_code)) begin
            errors++;
            $display("FAIL %s vld act=%b exp=1 code act=%0d exp=%0d (want %0d) pa act=%h exp=%h rwx act=%b exp=%b plv act=%0d exp=%0d",
                     tag, out_vld, out_code, ec, want_code, out_pa, epa,
                     {out_perm_r, out_perm_w, out_perm_x}, erwx, out_plv, ep);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] va0;
        va0 = 64'h0000_1234_5678_9ABC;
        in_vld = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_vld !== 1'b0 || out_code !== 3'd0 || out_pa !== '0 ||
            {out_perm_r, out_perm_w, out_perm_x} !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset act=%b/%0d/%h exp=0/0/0", out_vld, out_code, out_pa);
        end
        rst = 1'b0;

        // R2: invalid outranks every other fault
        cyc("R2 invalid+nx+priv", 1, mk(0,0,0,0,1,1,36'h12345), 12, 0, 3, va0, 1, 1);
        cyc("R2 invalid store",   1, mk(0,0,3,1,0,0,36'h1), 12, 2, 0, va0, 1, 1);
        // R3
        cyc("R3 fetch nx",        1, mk(1,1,3,0,1,1,36'h00ABC), 12, 0, 3, va0, 1, 2);
        cyc("R3 load nr",         1, mk(1,1,3,0,1,1,36'h00ABC), 12, 1, 0, va0, 1, 3);
        cyc("R3 store ignores nr nx", 1, mk(1,1,3,0,1,1,36'h00ABC), 12, 2, 1, va0, 1, 0);
        cyc("R3 fetch nx beats priv", 1, mk(1,0,0,1,1,1,36'h1), 12, 0, 2, va0, 1, 2);
        // R4
        cyc("R4 above entry",     1, mk(1,1,1,0,0,0,36'h5), 12, 1, 2, va0, 1, 4);
        cyc("R4 below entry ok",  1, mk(1,1,3,0,0,0,36'h5), 12, 1, 0, va0, 1, 0);
        cyc("R4 exact mismatch",  1, mk(1,1,3,1,0,0,36'h5), 12, 1, 0, va0, 1, 4);
        cyc("R4 exact equal",     1, mk(1,1,2,1,0,0,36'h5), 12, 1, 2, va0, 1, 0);
        // R5
        cyc("R5 store clean",     1, mk(1,0,3,0,0,0,36'h77), 12, 2, 0, va0, 1, 5);
        cyc("R5 priv beats dirty",1, mk(1,0,0,0,0,0,36'h77), 12, 2, 1, va0, 1, 4);
        // R6
        cyc("R6 narrow ignores nx", 1, mk(1,1,0,1,1,1,36'hF_FFFF_FFFF), 12, 0, 0, va0, 0, 0);
        cyc("R6 narrow ignores exact", 1, mk(1,1,3,1,1,1,36'hA_BCDE_F012), 12, 1, 1, va0, 0, 0);
        // R7
        cyc("R7 ps21 sw bits",    1, mk(1,1,0,0,0,0,36'h0_1234_51FF), 21, 1, 0, va0, 1, 0);
        cyc("R7 ps low clamp",    1, mk(1,1,0,0,0,0,36'h0_0000_0FFF), 5, 1, 0, va0, 1, 0);
        cyc("R7 ps high clamp",   1, mk(1,1,0,0,0,0,36'hF_FFFF_FFFF), 31, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
        // R8
        cyc("R8 read only",       1, mk(1,0,2,0,0,1,36'h3), 14, 1, 1, va0, 1, 0);
        cyc("R8 full rights",     1, mk(1,1,1,0,0,0,36'h3), 14, 0, 1, va0, 1, 0);
        // R9
        cyc("R9 alt acts as load nr", 1, mk(1,1,3,0,1,0,36'h9), 12, 3, 0, va0, 1, 3);
        cyc("R9 alt clean entry",     1, mk(1,0,3,0,0,0,36'h9), 12, 3, 0, va0, 1, 0);
        // R1 idle
        cyc("R1 idle",            0, mk(1,1,0,0,0,0,36'h9), 12, 0, 0, va0, 1, -1);
        cyc("R1 resume",          1, mk(1,1,0,0,0,0,36'h9), 12, 0, 0, va0, 1, 0);

        // mixed random: R2 R3 R4 R5 R6 R7 R8 priority and masking together
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] e, va;
            e  = {$urandom, $urandom};
            va = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) e[0] = 1'b1;
            cyc("R4 R7 random mix", ($urandom_range(0, 7) != 0), e,
                int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)), va, 1'($urandom_range(0, 1)), -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule